// File: doc/BRIEF.md
# Double-Buffered Serial Data Register

This block is the data path of a two-wire serial port. A shift register moves frame bits out to the bus, or in from the bus, on each accepted bit strobe. A receive holding register stands behind it. The processor sees a single data location: a write loads the shift register, and a read returns the holding register. Frames carry 1 to 8 data bits, acknowledge excluded, and bits can be shifted most-significant first or least-significant first.

In receive mode, a completed frame moves into the holding register right away if that register is empty, and a full flag is set. If the holding register is still full, the frame stays in the shift register. Shifting then pauses, and the frame is moved across by the next processor read. Short frames are justified by bit order. On transmit, the bits are taken from the end that is shifted first. On receive, the bits land at the opposite end.

Bus condition detection, clock timing, acknowledge, address matching and interrupts live elsewhere. Frame-done, direction and bit strobes come from the surrounding controller.

Top module: `i2c_dbuf`

## Requirements
- R1: In receive mode (`rx_mode`=1), a `frame_done` pulse while the holding register is empty and no frame is deferred copies the received frame into the holding register on that clock edge and sets `hold_full`.
- R2: In receive mode, a `frame_done` pulse while `hold_full`=1 keeps the frame in the shift register with `hold_full` still 1. The next enabled read returns the older holding value and moves the deferred frame in, and `hold_full` stays 1.
- R3: In transmit mode (`rx_mode`=0), frame completion never changes the holding register or sets `hold_full`.
- R4: On transmit, `sda_out` presents the bit to be sent before each accepted strobe. With `lsb_first`=0 the bits are data[7], data[6], and so on, so a short frame uses the upper bits. With `lsb_first`=1 the bits are data[0], data[1], and so on, so a short frame uses the lower bits.
- R5: On receive with n data bits, `lsb_first`=0 places the frame in bits n-1..0, with the first bit received at bit n-1. `lsb_first`=1 places the frame in bits 7..8-n, with the first bit received at bit 8-n. All other bits of the holding register read as 0.
- R6: While `en`=0, writes are ignored and `cpu_rdata` is 0. `cpu_rdata` is also 0 whenever no enabled read is in progress.
- R7: While `en`=0, `hold_full` is 0, any deferred frame is dropped, and the shift bit counter returns to zero.
- R8: An enabled read with no deferred frame clears `hold_full` on the next edge. If a receive `frame_done` arrives in the same cycle, the new frame is taken in directly and `hold_full` stays 1.
- R9: Bit strobes beyond the frame length are ignored. While a deferred frame waits, bit strobes and `frame_done` are ignored.
- R10: The 3-bit `frame_len` field gives the number of data bits, and 0 encodes 8.
- R11: After reset, `hold_full` is 0. The data registers have no defined reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| lsb_first | input | 1 | Bit order: 0 = most-significant first, 1 = least-significant first |
| frame_len | input | 3 | Data bits per frame, 0 encodes 8 |
| cpu_wr | input | 1 | Write strobe for the data location |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe for the data location |
| cpu_rdata | output | 8 | Read data, valid while `cpu_rd` is high |
| bit_strobe | input | 1 | Shift one bit this cycle |
| sda_in | input | 1 | Serial input bit |
| sda_out | output | 1 | Serial output bit |
| frame_done | input | 1 | End-of-frame pulse |
| hold_full | output | 1 | Holding register contains unread data |

## Verification
The hardest state to reach is a deferred frame: the holding register must be full and a second frame must complete before the first is read. That is also the only state in which bit strobes and frame completions must be ignored. The bench receives two frames back to back without reading and then pushes extra strobes and a stray `frame_done` with different bits. Two reads then show that the older value comes out first and that the deferred frame arrives intact. Other directed sequences place a read and a frame completion in the same cycle, and drop the enable in the middle of a frame to show that the bit counter restarts.

// File: rtl/i2c_dbuf_pkg.sv
package i2c_dbuf_pkg;
  typedef enum logic {
    ORD_MSB_FIRST = 1'b0,
    ORD_LSB_FIRST = 1'b1
  } bit_order_e;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;
endpackage

// File: rtl/i2c_dbuf_shift.sv
module i2c_dbuf_shift
  import i2c_dbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W),
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  dir_e              dir,
  input  bit_order_e        order,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_strobe,
  input  logic              sda_in,
  input  logic              frame_done,
  input  logic              stall,
  output logic              sda_out,
  output logic [DATA_W-1:0] shift_q,
  output logic [DATA_W-1:0] frame_word
);

  // Length field 0 stands for a full-width frame.
  function automatic logic [CNT_W-1:0] len_decode(input logic [LEN_W-1:0] f);
    return (f == '0) ? CNT_W'(DATA_W) : CNT_W'(f);
  endfunction

  // Keep only the received bits: low end for MSB-first, high end for LSB-first.
  function automatic logic [DATA_W-1:0] rx_justify(input logic [DATA_W-1:0] raw,
                                                   input logic [CNT_W-1:0]  nbits,
                                                   input bit_order_e        ord);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) begin
      if (ord == ORD_LSB_FIRST) r[i] = (i >= DATA_W - int'(nbits)) ? raw[i] : 1'b0;
      else                      r[i] = (i < int'(nbits))           ? raw[i] : 1'b0;
    end
    return r;
  endfunction

  // The bit leaving next sits at the end that is shifted first.
  function automatic logic tx_bit(input logic [DATA_W-1:0] raw, input bit_order_e ord);
    return (ord == ORD_LSB_FIRST) ? raw[0] : raw[DATA_W-1];
  endfunction

  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] nbits_live;
  logic [LEN_W-1:0] len_q;
  bit_order_e       ord_q;
  logic             shift_fire;
  logic             done_ok;

  assign nbits_live = len_decode(frame_len);
  assign done_ok    = frame_done && !stall;
  assign shift_fire = en && bit_strobe && !stall && (bit_cnt < nbits_live);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
    end else if (!en || frame_done || wr_ok) begin
      bit_cnt <= '0;
    end else if (shift_fire) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // Frame shape captured at completion, used when a deferred frame moves later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      ord_q <= ORD_MSB_FIRST;
    end else if (en && done_ok) begin
      len_q <= frame_len;
      ord_q <= order;
    end
  end

  // Data register: no defined reset value.
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      shift_q <= wr_data;
    end else if (shift_fire) begin
      if (order == ORD_LSB_FIRST) shift_q <= {sda_in, shift_q[DATA_W-1:1]};
      else                        shift_q <= {shift_q[DATA_W-2:0], sda_in};
    end
  end

  assign sda_out    = tx_bit(shift_q, order);
  assign frame_word = done_ok ? rx_justify(shift_q, nbits_live, order)
                              : rx_justify(shift_q, len_decode(len_q), ord_q);

  logic unused_dir;
  assign unused_dir = (dir == DIR_RX);

endmodule

// File: rtl/i2c_dbuf_hold.sv
module i2c_dbuf_hold
  import i2c_dbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  dir_e              dir,
  input  logic              frame_done,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] frame_word,
  output logic [DATA_W-1:0] hold_q,
  output logic              hold_full,
  output logic              pending,
  output logic              xfer_direct,
  output logic              xfer_deferred,
  output logic              defer_set
);

  logic full_after_rd;
  logic rx_done;

  // A read that is not bringing in a deferred frame empties the holder.
  assign full_after_rd = hold_full && !(rd_ok && !pending);
  assign rx_done       = en && (dir == DIR_RX) && frame_done && !pending;
  assign xfer_direct   = rx_done && !full_after_rd;
  assign defer_set     = rx_done &&  full_after_rd;
  assign xfer_deferred = rd_ok && pending;

  always_ff @(posedge clk) begin
    if (xfer_direct || xfer_deferred) hold_q <= frame_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      pending   <= 1'b0;
    end else if (!en) begin
      hold_full <= 1'b0;
      pending   <= 1'b0;
    end else begin
      if (xfer_direct || xfer_deferred) hold_full <= 1'b1;
      else if (rd_ok)                   hold_full <= 1'b0;
      if (defer_set)                    pending   <= 1'b1;
      else if (xfer_deferred)           pending   <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_dbuf.sv
module i2c_dbuf
  import i2c_dbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_mode,
  input  logic              lsb_first,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              bit_strobe,
  input  logic              sda_in,
  output logic              sda_out,
  input  logic              frame_done,
  output logic              hold_full
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  dir_e              dir;
  bit_order_e        order;
  logic              rd_ok;
  logic              wr_ok;
  logic              pending;
  logic              xfer_direct;
  logic              xfer_deferred;
  logic              defer_set;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] frame_word;

  assign dir   = rx_mode   ? DIR_RX : DIR_TX;
  assign order = lsb_first ? ORD_LSB_FIRST : ORD_MSB_FIRST;
  assign rd_ok = en && cpu_rd;
  assign wr_ok = en && cpu_wr;

  i2c_dbuf_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .dir        (dir),
    .order      (order),
    .frame_len  (frame_len),
    .wr_ok      (wr_ok),
    .wr_data    (cpu_wdata),
    .bit_strobe (bit_strobe),
    .sda_in     (sda_in),
    .frame_done (frame_done),
    .stall      (pending),
    .sda_out    (sda_out),
    .shift_q    (shift_q),
    .frame_word (frame_word)
  );

  i2c_dbuf_hold #(.DATA_W(DATA_W)) u_hold (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .dir           (dir),
    .frame_done    (frame_done),
    .rd_ok         (rd_ok),
    .frame_word    (frame_word),
    .hold_q        (hold_q),
    .hold_full     (hold_full),
    .pending       (pending),
    .xfer_direct   (xfer_direct),
    .xfer_deferred (xfer_deferred),
    .defer_set     (defer_set)
  );

  assign cpu_rdata = rd_ok ? hold_q : '0;

endmodule

// File: rtl/i2c_dbuf_chk.sv
module i2c_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              rx_mode,
  input logic              frame_done,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              bit_strobe,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              hold_full,
  input logic              pending,
  input logic              xfer_direct,
  input logic              xfer_deferred,
  input logic              defer_set,
  input logic [DATA_W-1:0] shift_q,
  input logic [DATA_W-1:0] hold_q
);

  a_r1_direct_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    en && rx_mode && frame_done && !hold_full && !pending |=> hold_full);

  a_r2_defer_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    defer_set |=> hold_full && pending);

  a_r2_read_moves_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    en && cpu_rd && pending |=> hold_full && !pending);

  a_r3_tx_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mode && !pending |=> $stable(hold_q));

  a_r6_disabled_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> cpu_rdata == '0);

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !hold_full && !pending);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    en && cpu_rd && !pending && !(rx_mode && frame_done) |=> !hold_full);

  a_r9_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    pending && bit_strobe && !cpu_wr |=> $stable(shift_q));

  a_r1_one_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_direct && xfer_deferred));

endmodule

bind i2c_dbuf i2c_dbuf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_i2c_dbuf.sv
module tb_i2c_dbuf;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       rx_mode = 1'b0;
  logic       lsb_first = 1'b0;
  logic [2:0] frame_len = 3'd0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_rdata;
  logic       bit_strobe = 1'b0;
  logic       sda_in = 1'b0;
  logic       sda_out;
  logic       frame_done = 1'b0;
  logic       hold_full;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i2c_dbuf dut (.*);

  // {is_rx, lsb_first, frame_len, stimulus, expected}
  // rx: stimulus bit 7 is sent first; expected is the read value.
  // tx: stimulus is the written data; expected holds the sent bits, first at bit 7.
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 8'hA5, 8'hA5},
    {1'b1, 1'b1, 3'd0, 8'h1E, 8'h78},
    {1'b1, 1'b0, 3'd3, 8'hC0, 8'h06},
    {1'b1, 1'b1, 3'd3, 8'hC0, 8'h60},
    {1'b1, 1'b0, 3'd5, 8'h58, 8'h0B},
    {1'b1, 1'b1, 3'd1, 8'h80, 8'h80},
    {1'b1, 1'b0, 3'd1, 8'h80, 8'h01},
    {1'b1, 1'b1, 3'd6, 8'hB4, 8'hB4},
    {1'b0, 1'b0, 3'd0, 8'h3C, 8'h3C},
    {1'b0, 1'b1, 3'd0, 8'h01, 8'h80},
    {1'b0, 1'b0, 3'd4, 8'hA0, 8'hA0},
    {1'b0, 1'b1, 3'd4, 8'h05, 8'hA0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic do_write(input logic [7:0] d);
    cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] d);
    cpu_rd = 1'b1; #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic strobe(input logic b);
    sda_in = b; bit_strobe = 1'b1;
    @(negedge clk); bit_strobe = 1'b0;
  endtask

  task automatic pulse_done();
    frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic rx_frame(input logic ord, input logic [2:0] len,
                          input logic [7:0] bits, input int nstb);
    rx_mode = 1'b1; lsb_first = ord; frame_len = len;
    for (int k = 0; k < nstb; k++) strobe(bits[7 - (k % 8)]);
    pulse_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset full", {7'd0, hold_full}, 8'h00);
    check("R6 idle rdata", cpu_rdata, 8'h00);
    en = 1'b1;
    @(negedge clk);

    // Table walk
    prev = 8'h00;
    for (int v = 0; v < NV; v++) begin
      logic       is_rx = VEC[v][20];
      logic       ord   = VEC[v][19];
      logic [2:0] len   = VEC[v][18:16];
      logic [7:0] stim  = VEC[v][15:8];
      logic [7:0] exp   = VEC[v][7:0];
      int         n     = (len == 0) ? 8 : int'(len);
      if (is_rx) begin
        rx_frame(ord, len, stim, n);
        check("R1 full after rx frame", {7'd0, hold_full}, 8'h01);
        do_read(rd);
        check("R5 R10 rx justify", rd, exp);
        check("R8 read clears full", {7'd0, hold_full}, 8'h00);
        prev = rd;
      end else begin
        logic [7:0] sent = 8'h00;
        rx_mode = 1'b0; lsb_first = ord; frame_len = len;
        do_write(stim);
        for (int k = 0; k < n; k++) begin
          sent[7 - k] = sda_out;
          strobe(1'b0);
        end
        pulse_done();
        check("R4 R10 tx bits", sent & (8'hFF << (8 - n)), exp);
        check("R3 tx sets no full", {7'd0, hold_full}, 8'h00);
        do_read(rd);
        check("R3 tx leaves holder", rd, prev);
      end
    end

    // R9: strobes past the frame length are ignored
    rx_frame(1'b0, 3'd3, 8'hBF, 5);
    do_read(rd);
    check("R9 extra strobes ignored", rd, 8'h05);

    // R2 / R9: deferred frame and stall
    rx_frame(1'b0, 3'd0, 8'h5A, 8);
    rx_frame(1'b0, 3'd0, 8'hC3, 8);
    check("R2 full while deferred", {7'd0, hold_full}, 8'h01);
    for (int k = 0; k < 4; k++) strobe(1'b1);
    pulse_done();
    do_read(rd);
    check("R2 first read older", rd, 8'h5A);
    check("R2 full kept after move", {7'd0, hold_full}, 8'h01);
    do_read(rd);
    check("R2 R9 deferred intact", rd, 8'hC3);
    check("R8 full clears", {7'd0, hold_full}, 8'h00);

    // R8: read and frame completion in the same cycle
    rx_frame(1'b0, 3'd0, 8'h11, 8);
    for (int k = 0; k < 8; k++) strobe(k[0]);
    frame_done = 1'b1; cpu_rd = 1'b1; #1 rd = cpu_rdata;
    @(negedge clk); frame_done = 1'b0; cpu_rd = 1'b0;
    check("R8 same-cycle old value", rd, 8'h11);
    check("R8 same-cycle full kept", {7'd0, hold_full}, 8'h01);
    do_read(rd);
    check("R8 same-cycle new frame", rd, 8'h55);

    // R7: disable clears full and restarts the bit counter
    rx_frame(1'b0, 3'd0, 8'h77, 8);
    en = 1'b0;
    @(negedge clk);
    check("R7 full cleared", {7'd0, hold_full}, 8'h00);
    do_read(rd);
    check("R6 disabled read zero", rd, 8'h00);
    en = 1'b1; rx_mode = 1'b1; lsb_first = 1'b0; frame_len = 3'd3;
    strobe(1'b1); strobe(1'b1);
    en = 1'b0; @(negedge clk); en = 1'b1;
    strobe(1'b0); strobe(1'b1); strobe(1'b1);
    pulse_done();
    do_read(rd);
    check("R7 counter restarted", rd, 8'h03);

    // R6: write ignored while disabled
    rx_mode = 1'b0; lsb_first = 1'b0; frame_len = 3'd0;
    do_write(8'h80);
    en = 1'b0;
    do_write(8'h00);
    en = 1'b1;
    @(negedge clk);
    check("R6 write ignored", {7'd0, sda_out}, 8'h01);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule